// File: doc/BRIEF.md
# Multiplexed General-Purpose I/O Line Controller

This block manages a bank of I/O lines. Each line is either run as a general-purpose pin, with its output value and output enable held in the block, or handed over to one of two on-chip peripherals, A or B, which then drive the pad directly. Every per-line setting is held in a configuration field. A field is written through a set address and a clear address: a 1 in the write data changes that line, and a 0 leaves it as it was. A third address reads the field back.

On the input side, every pad passes through a two-stage synchroniser. An optional per-line glitch filter follows the synchroniser. The conditioned level feeds the peripherals and a change detector. The detector keeps a sticky status bit per line, whatever mode the line is in. Reading that status clears it, and an interrupt is raised while any status bit is set on a line whose interrupt is enabled. Open-drain behaviour is emulated per line: the line drives only low and releases the pad otherwise. A masked data write updates the output values of many lines in one bus cycle.

Top module: `gpio_mux`

## Requirements
- R1: Reset state. After reset every line is in general-purpose mode with its output disabled and its pull-up on: `pad_oe` is all zeros and `pad_pu` is all ones. Field GPIO_EN and field PULL read all ones. Field OUT_EN and the change status read zero. `irq` is low.
- R2: Bus address layout and set/clear semantics. The bus address is {field[3:0], op[1:0]}, with op 0 = set, op 1 = clear and op 2 = read. A read returns its data on `bus_rdata` one cycle after `bus_rd`. The configuration fields are 0 GPIO_EN, 1 OUT_EN, 2 MULTI, 3 PULL, 4 FILT, 5 IRQ_EN, 6 SEL_B, 7 ODATA and 8 WR_MASK. A set write ORs the data into the field. A clear write removes the data bits from the field. Data bits that are 0 change nothing.
- R3: Output multiplexing. In general-purpose mode (GPIO_EN=1), a line drives ODATA under OUT_EN. In peripheral mode it drives `pa_out`/`pa_oe` when SEL_B=0 and `pb_out`/`pb_oe` when SEL_B=1. `pad_out` and `pad_oe` are registered one cycle after their sources.
- R4: Open drain. When MULTI is set for a line, `pad_out` is 0 and `pad_oe` is high only while the selected source enables its output and drives a 0.
- R5: `pad_pu` follows field PULL with one register stage.
- R6: Masked data write. A set write to field 9 loads ODATA only on lines whose WR_MASK bit is 1. The other lines keep their value.
- R7: Pin level. A read of field 9 (op 2) returns the pad level after the two-stage synchroniser.
- R8: Glitch filter. On a line with FILT=1, a pad pulse lasting one clock cycle never reaches `periph_in` or the change status. A pulse of three cycles or more does. With FILT=0, any pulse that the synchroniser captures passes through.
- R9: Change status. Field 10 (op 2) reads a sticky per-line bit that is set when the conditioned input changes, in any line mode. The read returns the bits and clears them.
- R10: `irq` is high one cycle after any change-status bit is set on a line whose IRQ_EN is 1. It stays low while the only set bits belong to disabled lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | {field, op} register address |
| bus_wdata | input | NLINES | Write data, one bit per line |
| bus_rdata | output | NLINES | Read data, valid one cycle after bus_rd |
| pa_out | input | NLINES | Peripheral A output values |
| pa_oe | input | NLINES | Peripheral A output enables |
| pb_out | input | NLINES | Peripheral B output values |
| pb_oe | input | NLINES | Peripheral B output enables |
| periph_in | output | NLINES | Conditioned pad level sent to the peripherals |
| pad_in | input | NLINES | Pad level |
| pad_out | output | NLINES | Pad drive value |
| pad_oe | output | NLINES | Pad drive enable |
| pad_pu | output | NLINES | Pad pull-up enable |
| irq | output | 1 | Change interrupt |

## Verification
The bench sweeps each line through set/clear writes. It also writes all-zero data, because a design that treated a 0 in set or clear data as an action would wipe neighbouring lines. Single-cycle pulses are driven on filtered and unfiltered lines together. A filter that is too weak would raise status on filtered lines. A filter that is too strong, or a change detector that misses a change that flips back, would leave unfiltered lines silent. The bench also mixes general-purpose, peripheral-A and peripheral-B lines with open drain on some of them, which catches a swapped selector or a pad driven high in open-drain mode. The masked write and clear-on-read are checked on lines both inside and outside the mask and the interrupt enable.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int FIELD_W = 4;
  localparam int OP_W    = 2;
  localparam int ADDR_W  = FIELD_W + OP_W;
  localparam int NCFG    = 9;

  typedef enum logic [FIELD_W-1:0] {
    F_GPIO  = 4'd0,
    F_OE    = 4'd1,
    F_MD    = 4'd2,
    F_PU    = 4'd3,
    F_FILT  = 4'd4,
    F_IEN   = 4'd5,
    F_BSEL  = 4'd6,
    F_ODATA = 4'd7,
    F_OWE   = 4'd8,
    F_DATA  = 4'd9,
    F_CHG   = 4'd10
  } field_e;

  typedef enum logic [OP_W-1:0] {
    OP_SET = 2'd0,
    OP_CLR = 2'd1,
    OP_RD  = 2'd2
  } op_e;

  // fields whose bits come out of reset as ones: GPIO_EN and PULL
  localparam logic [NCFG-1:0] CFG_RST_ONES = 9'b0_0000_1001;
endpackage

// File: rtl/gpio_cfg_field.sv
module gpio_cfg_field #(
  parameter int NLINES  = 32,
  parameter bit RST_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              ld_we,
  input  logic [NLINES-1:0] wdata,
  input  logic [NLINES-1:0] ld_mask,
  output logic [NLINES-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= {NLINES{RST_ONE}};
    else if (set_we)  q <= q | wdata;
    else if (clr_we)  q <= q & ~wdata;
    else if (ld_we)   q <= (q & ~ld_mask) | (wdata & ld_mask);
  end

  // R2
  set_only_chk: assert property (@(posedge clk) disable iff (rst)
    set_we |=> (((q & $past(wdata)) == $past(wdata)) &&
                ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));
  // R2
  clr_only_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> (((q & $past(wdata)) == '0) &&
                ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));
endmodule

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int NLINES   = 32,
  parameter int FILT_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pad_in,
  input  logic [NLINES-1:0] filt_en,
  output logic [NLINES-1:0] sync_lvl,
  output logic [NLINES-1:0] cond
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [NLINES-1:0] s1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q     <= '0;
      sync_lvl <= '0;
    end else begin
      s1_q     <= pad_in;
      sync_lvl <= s1_q;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q   <= '0;
        cond[i] <= 1'b0;
      end else if (!filt_en[i]) begin
        cnt_q   <= '0;
        cond[i] <= sync_lvl[i];
      end else if (sync_lvl[i] == cond[i]) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        cnt_q   <= '0;
        cond[i] <= sync_lvl[i];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8
  filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (((cond ^ $past(cond)) & $past(filt_en) & ~($past(sync_lvl) ~^ cond)) == '0));
endmodule

// File: rtl/gpio_out_drv.sv
module gpio_out_drv #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] gpio_en,
  input  logic [NLINES-1:0] out_en,
  input  logic [NLINES-1:0] multi,
  input  logic [NLINES-1:0] odata,
  input  logic [NLINES-1:0] sel_b,
  input  logic [NLINES-1:0] pull,
  input  logic [NLINES-1:0] pa_out,
  input  logic [NLINES-1:0] pa_oe,
  input  logic [NLINES-1:0] pb_out,
  input  logic [NLINES-1:0] pb_oe,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic [NLINES-1:0] pad_pu
);
  logic [NLINES-1:0] drv_val, drv_en, nxt_out, nxt_oe;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_comb begin
      if (gpio_en[i]) begin
        drv_val[i] = odata[i];
        drv_en[i]  = out_en[i];
      end else if (sel_b[i]) begin
        drv_val[i] = pb_out[i];
        drv_en[i]  = pb_oe[i];
      end else begin
        drv_val[i] = pa_out[i];
        drv_en[i]  = pa_oe[i];
      end
      nxt_out[i] = multi[i] ? 1'b0 : drv_val[i];
      nxt_oe[i]  = multi[i] ? (drv_en[i] & ~drv_val[i]) : drv_en[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '1;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
      pad_pu  <= pull;
    end
  end

  // R4
  od_low_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out & $past(multi)) == '0));
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] cond,
  input  logic [NLINES-1:0] ien,
  input  logic              rd_clr,
  output logic [NLINES-1:0] isr,
  output logic              irq
);
  logic [NLINES-1:0] prev_q, chg;

  assign chg = cond ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      isr    <= '0;
      irq    <= 1'b0;
    end else begin
      prev_q <= cond;
      isr    <= (rd_clr ? '0 : isr) | chg;
      irq    <= |(isr & ien);
    end
  end

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> ((isr & $past(isr)) == $past(isr)));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && (cond == prev_q)) |=> (isr == '0));
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((isr & ien) != '0));
endmodule

// File: rtl/gpio_mux.sv
module gpio_mux
  import gpio_mux_pkg::*;
#(
  parameter int NLINES   = 32,
  parameter int FILT_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [5:0]        bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pa_out,
  input  logic [NLINES-1:0] pa_oe,
  input  logic [NLINES-1:0] pb_out,
  input  logic [NLINES-1:0] pb_oe,
  output logic [NLINES-1:0] periph_in,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic [NLINES-1:0] pad_pu,
  output logic              irq
);
  logic [FIELD_W-1:0] fsel;
  logic [OP_W-1:0]    op;
  logic               data_wr, chg_rd;
  logic [NLINES-1:0]  cfg_q [NCFG];
  logic [NLINES-1:0]  sync_lvl, cond, isr;

  assign fsel    = bus_addr[ADDR_W-1:OP_W];
  assign op      = bus_addr[OP_W-1:0];
  assign data_wr = bus_wr && (fsel == F_DATA) && (op == OP_SET);
  assign chg_rd  = bus_rd && (fsel == F_CHG) && (op == OP_RD);

  for (genvar f = 0; f < NCFG; f++) begin : g_cfg
    gpio_cfg_field #(.NLINES(NLINES), .RST_ONE(CFG_RST_ONES[f])) u_field (
      .clk     (clk),
      .rst     (rst),
      .set_we  (bus_wr && (fsel == FIELD_W'(f)) && (op == OP_SET)),
      .clr_we  (bus_wr && (fsel == FIELD_W'(f)) && (op == OP_CLR)),
      .ld_we   ((f == int'(F_ODATA)) && data_wr),
      .wdata   (bus_wdata),
      .ld_mask (cfg_q[int'(F_OWE)]),
      .q       (cfg_q[f])
    );
  end

  gpio_in_cond #(.NLINES(NLINES), .FILT_LEN(FILT_LEN)) u_in (
    .clk      (clk),
    .rst      (rst),
    .pad_in   (pad_in),
    .filt_en  (cfg_q[int'(F_FILT)]),
    .sync_lvl (sync_lvl),
    .cond     (cond)
  );

  assign periph_in = cond;

  gpio_out_drv #(.NLINES(NLINES)) u_out (
    .clk     (clk),
    .rst     (rst),
    .gpio_en (cfg_q[int'(F_GPIO)]),
    .out_en  (cfg_q[int'(F_OE)]),
    .multi   (cfg_q[int'(F_MD)]),
    .odata   (cfg_q[int'(F_ODATA)]),
    .sel_b   (cfg_q[int'(F_BSEL)]),
    .pull    (cfg_q[int'(F_PU)]),
    .pa_out  (pa_out),
    .pa_oe   (pa_oe),
    .pb_out  (pb_out),
    .pb_oe   (pb_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_pu  (pad_pu)
  );

  gpio_chg_irq #(.NLINES(NLINES)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .cond   (cond),
    .ien    (cfg_q[int'(F_IEN)]),
    .rd_clr (chg_rd),
    .isr    (isr),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (op != OP_RD)                 bus_rdata <= '0;
      else if (fsel < FIELD_W'(NCFG))  bus_rdata <= cfg_q[fsel];
      else if (fsel == F_DATA)         bus_rdata <= sync_lvl;
      else if (fsel == F_CHG)          bus_rdata <= isr;
      else                             bus_rdata <= '0;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((pad_pu == '1) && (pad_oe == '0) && !irq));
endmodule

// File: tb/tb_gpio_mux.sv
module tb_gpio_mux;
  localparam int N = 32;
  localparam logic [3:0] F_GPIO = 0, F_OE = 1, F_MD = 2, F_PU = 3, F_FILT = 4,
                         F_IEN = 5, F_BSEL = 6, F_ODATA = 7, F_OWE = 8,
                         F_DATA = 9, F_CHG = 10;
  localparam logic [1:0] SET = 0, CLR = 1, RD = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [5:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
  logic [N-1:0] periph_in, pad_in = '0, pad_out, pad_oe, pad_pu;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  gpio_mux #(.NLINES(N), .FILT_LEN(2)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_out(pb_out), .pb_oe(pb_oe), .periph_in(periph_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] f, input logic [1:0] o, input logic [N-1:0] d);
    bus_wr = 1; bus_addr = {f, o}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] f, output logic [N-1:0] d);
    bus_rd = 1; bus_addr = {f, RD};
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [N-1:0] d, acc, P, A, B, g, b, v, e, M, W, D, F, base;
    bit ok;
    settle(4);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_pu", pad_pu, '1);
    check("R1 pad_oe", pad_oe, '0);
    check("R1 irq", N'(irq), '0);
    rd(F_GPIO, d); check("R1 gpio_en", d, '1);
    rd(F_PU, d);   check("R1 pull", d, '1);
    rd(F_OE, d);   check("R1 out_en", d, '0);
    rd(F_CHG, d);  check("R1 chg", d, '0);

    // R2 set/clear sweep, one line at a time
    acc = '0;
    for (int i = 0; i < N; i++) begin
      wr(F_OE, SET, N'(1) << i);
      acc |= N'(1) << i;
      rd(F_OE, d); check("R2 set sweep", d, acc);
    end
    wr(F_OE, CLR, 32'hAAAA_AAAA);
    rd(F_OE, d); check("R2 clear", d, 32'h5555_5555);
    wr(F_OE, SET, '0);
    rd(F_OE, d); check("R2 zero set ignored", d, 32'h5555_5555);
    wr(F_OE, CLR, '0);
    rd(F_OE, d); check("R2 zero clr ignored", d, 32'h5555_5555);

    // R3 mux among GPIO / A / B
    P = 32'h1234_5678; A = 32'hF0F0_F0F0; B = 32'h3C3C_3C3C;
    pa_out = A; pa_oe = 32'h0FF0_0FF0; pb_out = B; pb_oe = 32'hFFFF_0000;
    wr(F_OE, SET, '1);
    wr(F_ODATA, SET, P);
    wr(F_GPIO, CLR, 32'h0000_FFFF);
    wr(F_BSEL, SET, 32'h0000_FF00);
    settle(2);
    g = 32'hFFFF_0000; b = 32'h0000_FF00;
    v = (g & P) | (~g & ~b & A) | (~g & b & B);
    e = g | (~g & ~b & pa_oe) | (~g & b & pb_oe);
    check("R3 pad_out mix", pad_out, v);
    check("R3 pad_oe mix", pad_oe, e);
    pa_out = ~A;
    @(negedge clk);
    v = (g & P) | (~g & ~b & ~A) | (~g & b & B);
    check("R3 peripheral A follows", pad_out, v);

    // R4 open drain on a subset
    M = 32'h00FF_00FF;
    wr(F_MD, SET, M);
    settle(2);
    check("R4 od pad_out", pad_out, ~M & v);
    check("R4 od pad_oe", pad_oe, (~M & e) | (M & e & ~v));
    wr(F_MD, CLR, M);

    // R5 pull-up
    wr(F_PU, CLR, 32'h0F0F_0F0F);
    settle(2);
    check("R5 pull clear", pad_pu, 32'hF0F0_F0F0);
    wr(F_PU, SET, 32'h0100_0000);
    settle(2);
    check("R5 pull set", pad_pu, 32'hF1F0_F0F0);

    // R6 masked data write
    W = 32'hFFFF_0000; D = 32'hCAFE_BABE;
    wr(F_OWE, SET, W);
    wr(F_DATA, SET, D);
    rd(F_ODATA, d); check("R6 masked write", d, (P & ~W) | (D & W));
    settle(1);
    check("R6 pad follows", pad_out & g, D & W);
    wr(F_OWE, CLR, '1);
    wr(F_DATA, SET, 32'h0);
    rd(F_ODATA, d); check("R6 no mask no change", d, (P & ~W) | (D & W));

    // R7 pin level
    pad_in = 32'h89AB_CDEF;
    settle(3);
    rd(F_DATA, d); check("R7 pin level", d, 32'h89AB_CDEF);
    pad_in = 32'h7654_3210;
    settle(3);
    rd(F_DATA, d); check("R7 pin level 2", d, 32'h7654_3210);

    // R9 sticky change status, clear on read
    settle(6);
    rd(F_CHG, d);
    settle(8);
    rd(F_CHG, d); check("R9 stable no change", d, '0);
    pad_in ^= 32'h00F0_000F;
    settle(8);
    rd(F_CHG, d); check("R9 change bits", d, 32'h00F0_000F);
    rd(F_CHG, d); check("R9 clear on read", d, '0);

    // R8 glitch filter
    F = 32'hFFFF_0000;
    wr(F_FILT, SET, F);
    base = pad_in;
    settle(4);
    rd(F_CHG, d);
    pad_in = ~base;
    @(negedge clk);
    pad_in = base;
    ok = 1;
    for (int k = 0; k < 6; k++) begin
      if ((periph_in & F) !== (base & F)) ok = 0;
      @(negedge clk);
    end
    check("R8 filtered periph_in held", N'(ok), N'(1));
    settle(4);
    rd(F_CHG, d); check("R8 one-cycle pulse", d, ~F);
    check("R8 periph_in", periph_in, base);
    pad_in = ~base;
    settle(3);
    pad_in = base;
    settle(10);
    rd(F_CHG, d); check("R8 long pulse", d, '1);

    // R10 interrupt
    wr(F_FILT, CLR, '1);
    rd(F_CHG, d);
    wr(F_IEN, SET, 32'h8);
    pad_in ^= 32'h20;
    settle(8);
    check("R10 disabled line no irq", N'(irq), '0);
    rd(F_CHG, d); check("R10 status of disabled line", d, 32'h20);
    pad_in ^= 32'h8;
    settle(8);
    check("R10 irq raised", N'(irq), N'(1));
    rd(F_CHG, d);
    settle(2);
    check("R10 irq cleared", N'(irq), '0);

    summary();
  end
endmodule